// File: doc/BRIEF.md
# Zero-Skip Loop Program Counter

This block sequences the program counter of an unrolled loop in which every iteration is a fixed-length run of instructions that multiplies one weight element. A mask register holds one bit per weight and marks the nonzero ones. The loop body has no compare-and-branch instructions. When the last instruction of an iteration has been fetched, the block looks for the nearest marked iteration above the current one. It then moves the PC straight to that iteration's first instruction, so iterations whose weight is zero are never fetched.

A start pulse loads the mask and latches the iteration length. It also positions the PC on the lowest marked iteration, computed from the supplied loop base address. Each fetch-advance strobe moves the PC by one instruction or performs the jump. Once no marked iteration remains, the PC lands on the first address past the loop and a one-cycle done flag is raised. The next-bit search and the jump address are computed in the same cycle, so there is no idle cycle between iterations.

Top module: `zskip_pc_seq`

## Requirements
- R1: On a start pulse with a nonzero mask, the outputs after that clock edge are pc = base + f*len, iter = f and valid = 1. Here f is the lowest set bit of the mask, and bit i set means weight i is nonzero.
- R2: While valid, each advance cycle that is not on the last instruction of an iteration increments pc by exactly 1 and leaves iter unchanged.
- R3: An advance on the last instruction (offset len-1) of iteration i, where n is the lowest set bit above i, sets iter to n and pc to (base + i*len) + (n-i)*len.
- R4: Whenever valid is high, the mask bit at index iter is set.
- R5: An advance on the last instruction of the highest set bit clears valid, sets pc to base + MASK_W*len and raises done for exactly one cycle.
- R6: A start pulse with an all-zero mask gives valid = 0, done = 1 for one cycle and pc = base + MASK_W*len, with no iteration presented.
- R7: With valid high and the advance strobe low, pc and iter hold their values.
- R8: A start pulse during a running loop takes priority over a simultaneous advance. It restarts the sequence with the new mask, base and length, as in R1.
- R9: After synchronous reset, pc = 0, iter = 0, valid = 0 and done = 0.
- R10: While valid is low, the advance strobe has no effect on pc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load mask, base and length, and begin the loop |
| mask_in | input | MASK_W | Nonzero-weight mask, bit i = weight i nonzero |
| base_in | input | PC_W | Address of the first instruction of iteration 0 |
| iter_len | input | LEN_W | Instructions per iteration, 1 to 15 |
| adv | input | 1 | Fetch-advance strobe |
| pc_o | output | PC_W | Current program counter |
| iter_o | output | IDX_W | Index of the iteration being fetched |
| valid_o | output | 1 | pc_o addresses an instruction inside the loop |
| done_o | output | 1 | One-cycle pulse when the loop ends |

## Verification
The sequence is swept over every iteration length from 1 to 15, each with an all-ones mask, single bits at the lowest and highest positions, two alternating patterns and seeded random masks. Each expected PC is computed as base + i*len + k. The all-ones and alternating masks separate an increment-by-one fault from a jump that miscounts the skip distance. The edge single-bit masks expose errors in the first-bit search and in the exit address. Runs with idle advance cycles inserted check the hold behaviour. An all-zero mask and a restart in the middle of a loop cover the empty-loop and override paths.

// File: rtl/zskip_pkg.sv
package zskip_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_INSTR = 2'd1,
    STEP_JUMP  = 2'd2,
    STEP_EXIT  = 2'd3
  } step_e;

endpackage

// File: rtl/zskip_scan.sv
module zskip_scan #(
  parameter int W     = 36,
  parameter int IDX_W = 6
) (
  input  logic [W-1:0]     mask,
  input  logic [IDX_W-1:0] cur,
  input  logic             from_zero,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  logic [W-1:0] elig;

  // Keep only bits strictly above the current index, or all bits on a restart.
  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_elig
      assign elig[g] = mask[g] & (from_zero | (IDX_W'(g) > cur));
    end
  endgenerate

  // Lowest eligible bit wins.
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
  end

  assign found = |elig;

endmodule

// File: rtl/zskip_addr.sv
module zskip_addr #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 6,
  parameter int LEN_W = 4
) (
  input  logic [PC_W-1:0]  origin,
  input  logic [CNT_W-1:0] count,
  input  logic [LEN_W-1:0] len,
  output logic [PC_W-1:0]  addr
);

  localparam int PROD_W = CNT_W + LEN_W;

  logic [PROD_W-1:0] prod;

  assign prod = PROD_W'(count) * PROD_W'(len);
  assign addr = origin + PC_W'(prod);

endmodule

// File: rtl/zskip_pc_seq.sv
module zskip_pc_seq
  import zskip_pkg::*;
#(
  parameter int MASK_W = 36,
  parameter int PC_W   = 16,
  parameter int LEN_W  = 4,
  parameter int IDX_W  = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MASK_W-1:0] mask_in,
  input  logic [PC_W-1:0]   base_in,
  input  logic [LEN_W-1:0]  iter_len,
  input  logic              adv,
  output logic [PC_W-1:0]   pc_o,
  output logic [IDX_W-1:0]  iter_o,
  output logic              valid_o,
  output logic              done_o
);

  localparam int CNT_W = $clog2(MASK_W + 1);

  logic [MASK_W-1:0] mask_q;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  off_q;
  logic [PC_W-1:0]   istart_q;

  logic [MASK_W-1:0] scan_mask;
  logic              found;
  logic [IDX_W-1:0]  nxt_idx;
  logic              last;
  logic [PC_W-1:0]   origin;
  logic [CNT_W-1:0]  count;
  logic [LEN_W-1:0]  len_sel;
  logic [PC_W-1:0]   jump_pc;
  step_e             step;

  assign scan_mask = start ? mask_in : mask_q;
  assign last      = (off_q == len_q - LEN_W'(1));

  zskip_scan #(.W(MASK_W), .IDX_W(IDX_W)) u_scan (
    .mask      (scan_mask),
    .cur       (iter_o),
    .from_zero (start),
    .found     (found),
    .idx       (nxt_idx)
  );

  // Start: base + first*len. Later: iteration start + skip*len, where the
  // skip runs to the loop end when no marked iteration remains.
  always_comb begin
    if (start) begin
      origin  = base_in;
      len_sel = iter_len;
      count   = found ? CNT_W'(nxt_idx) : CNT_W'(MASK_W);
    end else begin
      origin  = istart_q;
      len_sel = len_q;
      count   = found ? (CNT_W'(nxt_idx) - CNT_W'(iter_o))
                      : (CNT_W'(MASK_W) - CNT_W'(iter_o));
    end
  end

  zskip_addr #(.PC_W(PC_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_addr (
    .origin (origin),
    .count  (count),
    .len    (len_sel),
    .addr   (jump_pc)
  );

  always_comb begin
    step = STEP_HOLD;
    if (valid_o && adv) begin
      if (!last)      step = STEP_INSTR;
      else if (found) step = STEP_JUMP;
      else            step = STEP_EXIT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      len_q    <= '0;
      off_q    <= '0;
      istart_q <= '0;
      pc_o     <= '0;
      iter_o   <= '0;
      valid_o  <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start) begin
        mask_q   <= mask_in;
        len_q    <= iter_len;
        off_q    <= '0;
        pc_o     <= jump_pc;
        istart_q <= jump_pc;
        iter_o   <= found ? nxt_idx : '0;
        valid_o  <= found;
        done_o   <= !found;
      end else begin
        unique case (step)
          STEP_INSTR: begin
            pc_o  <= pc_o + PC_W'(1);
            off_q <= off_q + LEN_W'(1);
          end
          STEP_JUMP: begin
            pc_o     <= jump_pc;
            istart_q <= jump_pc;
            iter_o   <= nxt_idx;
            off_q    <= '0;
          end
          STEP_EXIT: begin
            pc_o    <= jump_pc;
            off_q   <= '0;
            valid_o <= 1'b0;
            done_o  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Assertions
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (valid_o && adv && !start && !last) |=> (pc_o == $past(pc_o) + PC_W'(1)));

  assert_forward_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && adv && !start && last && found) |=> (iter_o > $past(iter_o)));

  assert_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> mask_q[iter_o]);

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start) |=> !done_o);

  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(valid_o && done_o));

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !adv && !start) |=> ($stable(pc_o) && $stable(iter_o)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !start) |=> $stable(pc_o));

endmodule

// File: tb/zskip_pc_seq_bench.sv
module zskip_pc_seq_bench;

  localparam int W     = 36;
  localparam int PC_W  = 16;
  localparam int LEN_W = 4;
  localparam int IDX_W = 6;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [W-1:0]     mask_in = '0;
  logic [PC_W-1:0]  base_in = '0;
  logic [LEN_W-1:0] iter_len = '0;
  logic             adv = 1'b0;
  logic [PC_W-1:0]  pc_o;
  logic [IDX_W-1:0] iter_o;
  logic             valid_o;
  logic             done_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  zskip_pc_seq #(.MASK_W(W), .PC_W(PC_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_zskip_pc_seq (
    .clk(clk), .rst(rst), .start(start), .mask_in(mask_in), .base_in(base_in),
    .iter_len(iter_len), .adv(adv), .pc_o(pc_o), .iter_o(iter_o),
    .valid_o(valid_o), .done_o(done_o)
  );

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Called at a negedge; returns at the negedge after the start edge.
  task automatic kick(logic [W-1:0] m, logic [PC_W-1:0] b, int len);
    start = 1'b1; mask_in = m; base_in = b; iter_len = LEN_W'(len); adv = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_loop(logic [W-1:0] m, logic [PC_W-1:0] b, int len, int gap);
    int first = 1;
    logic [31:0] end_pc;
    end_pc = 32'(b) + 32'(W * len);
    kick(m, b, len);
    if (m == '0) begin
      chk("R6", "done", 32'(done_o), 1);
      chk("R6", "valid", 32'(valid_o), 0);
      chk("R6", "pc", 32'(pc_o), end_pc);
      @(negedge clk);
      chk("R6", "done drop", 32'(done_o), 0);
      return;
    end
    for (int i = 0; i < W; i++) begin
      if (m[i]) begin
        for (int k = 0; k < len; k++) begin
          string rq;
          rq = (first == 1) ? "R1" : ((k == 0) ? "R3" : "R2");
          first = 0;
          chk(rq, "pc", 32'(pc_o), 32'(b) + 32'(i * len + k));
          chk(rq, "iter", 32'(iter_o), 32'(i));
          chk(rq, "valid", 32'(valid_o), 1);
          chk("R4", "mask bit", 32'(m[iter_o]), 1);
          if (gap != 0 && ((i + k) % gap) == 0) begin
            adv = 1'b0;
            @(negedge clk);
            chk("R7", "pc hold", 32'(pc_o), 32'(b) + 32'(i * len + k));
            chk("R7", "iter hold", 32'(iter_o), 32'(i));
          end
          adv = 1'b1;
          @(negedge clk);
          adv = 1'b0;
        end
      end
    end
    chk("R5", "done", 32'(done_o), 1);
    chk("R5", "valid", 32'(valid_o), 0);
    chk("R5", "pc", 32'(pc_o), end_pc);
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
    chk("R5", "done one cycle", 32'(done_o), 0);
    chk("R10", "idle pc", 32'(pc_o), end_pc);
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: got running expected finished");
    report();
  end

  initial begin
    logic [W-1:0] masks [8];
    logic [63:0]  r;
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "pc", 32'(pc_o), 0);
    chk("R9", "iter", 32'(iter_o), 0);
    chk("R9", "valid", 32'(valid_o), 0);
    chk("R9", "done", 32'(done_o), 0);

    masks[0] = '1;
    masks[1] = W'(1);
    masks[2] = W'(1) << (W - 1);
    masks[3] = 36'h5_5555_5555;
    masks[4] = 36'hA_AAAA_AAAA;
    for (int j = 5; j < 8; j++) begin
      r = {$urandom(), $urandom()};
      masks[j] = r[W-1:0];
    end

    for (int len = 1; len <= 15; len++) begin
      for (int j = 0; j < 8; j++) begin
        run_loop(masks[j], PC_W'(16'h0400 + len * 16 + j), len, (j % 3 == 0) ? 0 : 3 + j % 2);
      end
      run_loop('0, PC_W'(16'h2000 + len), len, 0);
    end

    // R8: restart in the middle of a running loop, start beats advance
    kick(36'h0_0000_0F00, 16'h1000, 5);
    adv = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b1; mask_in = 36'h8_0000_0010; base_in = 16'h3000; iter_len = 4'd7;
    @(negedge clk);
    start = 1'b0; adv = 1'b0;
    chk("R8", "pc", 32'(pc_o), 32'h3000 + 4 * 7);
    chk("R8", "iter", 32'(iter_o), 4);
    chk("R8", "valid", 32'(valid_o), 1);
    run_loop(36'h8_0000_0010, 16'h3000, 7, 2);

    report();
  end

endmodule